// File: doc/BRIEF.md
# Instruction Fetch Front End with Stall Stash

This block is the front of an instruction pipeline. It feeds decode from a synchronous instruction memory that answers one cycle after it is addressed. The address stage holds the fetch address in a register, and that register drives the memory address pins with no logic in between. The memory returns its word through its own output register on the next clock. The output stage hands the instruction and its address to decode.

The memory never waits. The word that sits at the output when decode stalls would be overwritten on the next clock. To keep it, a one-entry stash register catches that word and its address. When the stall clears, the stash is replayed ahead of the live memory output. No word is lost, none is repeated, and no bubble opens after a stall.

A redirect loads a new fetch target and discards everything already fetched. A debug halt input freezes the fetch address. A step pulse issued during a halt lets exactly one further instruction through.

Top module: `ifs_front`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. The first instruction presented after reset has address `RESET_VEC`.
- R2: `imem_addr` is the registered fetch address. The memory returns the word one clock later, and every valid output carries in `out_insn` the memory word at `out_addr`.
- R3: With no stall, halt or redirect, one instruction is presented per cycle, and each consumed address is the previous one plus 4 (the instruction width in bytes).
- R4: While `dec_stall` is high and no redirect occurs, a valid output stays valid, with `out_addr` and `out_insn` unchanged.
- R5: After a stall of any length or pattern, the consumed addresses continue with no gap and no repeat. The cycle after a stall clears delivers a valid instruction, with no bubble. The stash and the live memory word are never both pending.
- R6: The stash is filled only in a cycle where `dec_stall` is high.
- R7: In the cycle `redirect_valid` is high and in the next cycle, `out_valid` is 0. Any stashed word is discarded, even during a stall. The first instruction presented afterwards is at the redirect target, two cycles after the redirect.
- R8: The two low bits of `redirect_target` are ignored: the target is forced to word alignment.
- R9: While `dbg_stop` is high and no step credit is pending, the fetch address is frozen. After at most one in-flight word, no valid output appears.
- R10: A `dbg_step` pulse while `dbg_stop` is high lets exactly one instruction through, the next sequential one, and fetch is then stopped again.
- R11: When `dbg_stop` falls, fetch resumes at the address that follows the last instruction delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect_valid | input | 1 | Load a new fetch target this cycle |
| redirect_target | input | ADDR_W | New fetch byte address |
| dec_stall | input | 1 | Decode cannot take the presented instruction this cycle |
| dbg_stop | input | 1 | Debug halt level |
| dbg_step | input | 1 | Debug single-step request, used while halted |
| imem_addr | output | ADDR_W | Instruction memory read byte address |
| imem_rdata | input | INSN_W | Registered memory output for the previous cycle's address |
| out_valid | output | 1 | Instruction presented to decode |
| out_insn | output | INSN_W | Instruction word |
| out_addr | output | ADDR_W | Byte address of the instruction |

## Verification
A free-running stream from reset sets the baseline order and throughput. Three stall shapes are then applied to that stream. A single-cycle stall shows whether the stash replays without a bubble. A four-cycle stall shows whether the held word stays put while the memory keeps reading. Alternating stall and release shows whether the stash and the live word ever collide and whether any word is dropped or repeated. Redirects are tried from a running stream, with a misaligned target, and in the middle of a stall, which separates ordinary flushing from discarding a full stash. Halt, step and resume then confirm that the frozen address, the single-word step and the restart point line up.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

   // Source feeding the decode-facing output
   typedef enum logic [1:0] {
      IFS_SRC_NONE  = 2'd0,
      IFS_SRC_LIVE  = 2'd1,
      IFS_SRC_STASH = 2'd2
   } ifs_src_e;

   // Fetch address stage operating mode
   typedef enum logic [1:0] {
      IFS_RUN  = 2'd0,
      IFS_HALT = 2'd1,
      IFS_STEP = 2'd2
   } ifs_mode_e;

endpackage

// File: rtl/ifs_addr_stage.sv
module ifs_addr_stage
   import ifs_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 32,
   parameter int unsigned          INSN_W    = 32,
   parameter logic [ADDR_W-1:0]    RESET_VEC = 'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_valid,
   input  logic [ADDR_W-1:0] redirect_target,
   input  logic              dec_stall,
   input  logic              dbg_stop,
   input  logic              dbg_step,
   output logic [ADDR_W-1:0] nia,
   output logic              issue
);

   localparam int unsigned       STEP_BYTES = INSN_W / 8;
   localparam logic [ADDR_W-1:0] STEP_INC   = ADDR_W'(STEP_BYTES);
   localparam logic [ADDR_W-1:0] LOW_MASK   = STEP_INC - 1'b1;

   logic [ADDR_W-1:0] nia_q;
   logic [ADDR_W-1:0] nia_d;
   logic              step_credit;
   logic              credit_d;
   logic              advance;
   ifs_mode_e         mode;

   always_comb begin
      if (!dbg_stop)        mode = IFS_RUN;
      else if (step_credit) mode = IFS_STEP;
      else                  mode = IFS_HALT;
   end

   // A read only counts when the address moves past it
   assign advance = (mode != IFS_HALT) && !dec_stall && !redirect_valid;
   assign issue   = advance;

   always_comb begin
      if (redirect_valid)  nia_d = redirect_target & ~LOW_MASK;
      else if (advance)    nia_d = nia_q + STEP_INC;
      else                 nia_d = nia_q;
   end

   // Credit survives stalls and redirects, is spent by one advance
   assign credit_d = dbg_stop && ((step_credit && !advance) || dbg_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nia_q       <= RESET_VEC;
         step_credit <= 1'b0;
      end else begin
         nia_q       <= nia_d;
         step_credit <= credit_d;
      end
   end

   assign nia = nia_q;

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_stop && !step_credit && !dbg_step && !redirect_valid) |=> $stable(nia_q)); // R9

   AST_STEP_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_stop && step_credit && !dec_stall && !redirect_valid && !dbg_step)
         |=> (!step_credit && nia_q == $past(nia_q) + STEP_INC)); // R10

endmodule

// File: rtl/ifs_read_track.sv
module ifs_read_track #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] nia,
   output logic              rd_v,
   output logic [ADDR_W-1:0] rd_addr
);

   // Mirrors the memory's one-cycle read: tags the word now arriving
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v    <= 1'b0;
         rd_addr <= '0;
      end else begin
         rd_v    <= issue;
         rd_addr <= nia;
      end
   end

endmodule

// File: rtl/ifs_stash_stage.sv
module ifs_stash_stage
   import ifs_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned INSN_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_valid,
   input  logic              dec_stall,
   input  logic              rd_v,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [INSN_W-1:0] rd_insn,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [INSN_W-1:0] out_insn
);

   localparam logic [ADDR_W-1:0] STEP_INC = ADDR_W'(INSN_W / 8);

   logic              stash_v_q;
   logic [ADDR_W-1:0] stash_addr_q;
   logic [INSN_W-1:0] stash_insn_q;
   logic              load_stash;
   ifs_src_e          src;

   always_comb begin
      if (stash_v_q)  src = IFS_SRC_STASH;
      else if (rd_v)  src = IFS_SRC_LIVE;
      else            src = IFS_SRC_NONE;
   end

   always_comb begin
      unique case (src)
         IFS_SRC_STASH: begin
            out_addr = stash_addr_q;
            out_insn = stash_insn_q;
         end
         default: begin
            out_addr = rd_addr;
            out_insn = rd_insn;
         end
      endcase
   end

   assign out_valid  = (src != IFS_SRC_NONE) && !redirect_valid;
   assign load_stash = (src == IFS_SRC_LIVE) && dec_stall && !redirect_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stash_v_q <= 1'b0;
      end else if (redirect_valid) begin
         stash_v_q <= 1'b0;
      end else if (stash_v_q) begin
         stash_v_q <= dec_stall;
      end else begin
         stash_v_q <= load_stash;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stash_addr_q <= '0;
         stash_insn_q <= '0;
      end else if (load_stash) begin
         stash_addr_q <= rd_addr;
         stash_insn_q <= rd_insn;
      end
   end

   AST_STASH_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stash_v_q) |-> $past(dec_stall)); // R6

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(stash_v_q && rd_v)); // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && dec_stall && !redirect_valid)
         |=> (redirect_valid || (out_valid && $stable(out_addr) && $stable(out_insn)))); // R4

   AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !dec_stall)
         |=> (!out_valid || out_addr == $past(out_addr) + STEP_INC)); // R3

   AST_REDIRECT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !out_valid); // R7

endmodule

// File: rtl/ifs_front.sv
module ifs_front #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       INSN_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_valid,
   input  logic [ADDR_W-1:0] redirect_target,
   input  logic              dec_stall,
   input  logic              dbg_stop,
   input  logic              dbg_step,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [INSN_W-1:0] imem_rdata,
   output logic              out_valid,
   output logic [INSN_W-1:0] out_insn,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int unsigned       STEP_BYTES = INSN_W / 8;
   localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'(STEP_BYTES - 1);

   initial begin
      if ((INSN_W % 8) != 0 || INSN_W < 8)
         $error("ifs_front: INSN_W must be a whole number of bytes");
      if ((STEP_BYTES & (STEP_BYTES - 1)) != 0)
         $error("ifs_front: INSN_W must be a power-of-two byte count");
      if (ADDR_W < 8)
         $error("ifs_front: ADDR_W too narrow");
      if ((RESET_VEC & LOW_MASK) != '0)
         $error("ifs_front: RESET_VEC must be instruction aligned");
   end

   logic [ADDR_W-1:0] nia;
   logic              issue;
   logic              rd_v;
   logic [ADDR_W-1:0] rd_addr;

   ifs_addr_stage #(
      .ADDR_W    (ADDR_W),
      .INSN_W    (INSN_W),
      .RESET_VEC (RESET_VEC)
   ) u_addr (
      .clk             (clk),
      .rst_n           (rst_n),
      .redirect_valid  (redirect_valid),
      .redirect_target (redirect_target),
      .dec_stall       (dec_stall),
      .dbg_stop        (dbg_stop),
      .dbg_step        (dbg_step),
      .nia             (nia),
      .issue           (issue)
   );

   // Memory address straight from the fetch address register
   assign imem_addr = nia;

   ifs_read_track #(
      .ADDR_W (ADDR_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (issue),
      .nia     (nia),
      .rd_v    (rd_v),
      .rd_addr (rd_addr)
   );

   ifs_stash_stage #(
      .ADDR_W (ADDR_W),
      .INSN_W (INSN_W)
   ) u_stash (
      .clk            (clk),
      .rst_n          (rst_n),
      .redirect_valid (redirect_valid),
      .dec_stall      (dec_stall),
      .rd_v           (rd_v),
      .rd_addr        (rd_addr),
      .rd_insn        (imem_rdata),
      .out_valid      (out_valid),
      .out_addr       (out_addr),
      .out_insn       (out_insn)
   );

   AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && rst_n) |-> !out_valid); // R1

endmodule

// File: tb/ifs_front_test.sv
`timescale 1ns/1ps
module ifs_front_test;

   localparam logic [31:0] RVEC = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redirect_valid = 1'b0;
   logic [31:0] redirect_target = '0;
   logic        dec_stall = 1'b0;
   logic        dbg_stop = 1'b0;
   logic        dbg_step = 1'b0;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata = '0;
   logic        out_valid;
   logic [31:0] out_insn;
   logic [31:0] out_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ifs_front #(.ADDR_W(32), .INSN_W(32), .RESET_VEC(RVEC)) uut (
      .clk(clk), .rst_n(rst_n),
      .redirect_valid(redirect_valid), .redirect_target(redirect_target),
      .dec_stall(dec_stall), .dbg_stop(dbg_stop), .dbg_step(dbg_step),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .out_valid(out_valid), .out_insn(out_insn), .out_addr(out_addr)
   );

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {a[15:0] ^ 16'h3C5A, ~a[17:2]};
   endfunction

   // Synchronous memory with registered output
   always @(posedge clk) imem_rdata <= mem_word(imem_addr);

   // Consumption log and per-cycle observations
   logic [31:0] q[$];
   logic [31:0] last_addr = '0;
   int          ins_err = 0;
   int          hold_err = 0;
   logic        p_v = 0, p_st = 0, p_rd = 0;
   logic [31:0] p_a = '0, p_i = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_insn !== mem_word(out_addr)) ins_err++;
         if (p_v && p_st && !p_rd && !redirect_valid)
            if (!(out_valid && out_addr == p_a && out_insn == p_i)) hold_err++;
         if (out_valid && !dec_stall) begin
            q.push_back(out_addr);
            last_addr = out_addr;
         end
      end
      p_v = out_valid; p_st = dec_stall; p_rd = redirect_valid;
      p_a = out_addr;  p_i = out_insn;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_run(input logic [31:0] start, input string req);
      int bad = -1;
      for (int i = 0; i < q.size(); i++)
         if (bad < 0 && q[i] != start + 32'(4 * i)) bad = i;
      check(bad < 0, req, (bad < 0) ? 32'h0 : q[bad], (bad < 0) ? 32'h0 : start + 32'(4 * bad));
   endtask

   task automatic t_reset_stream();
      tick(3);
      check(out_valid == 1'b0, "R1 idle in reset", {31'b0, out_valid}, 32'h0);
      q.delete();
      rst_n = 1'b1;
      tick(12);
      check(q.size() == 11, "R3 one per cycle", q.size(), 11);
      check(q.size() > 0 && q[0] == RVEC, "R1 first address", (q.size() > 0) ? q[0] : 32'hx, RVEC);
      check_run(RVEC, "R3 sequential +4");
      check(ins_err == 0, "R2 insn matches memory", ins_err, 0);
   endtask

   task automatic t_stall(input string name, input bit pat[], input int stalls);
      logic [31:0] start;
      int h0 = hold_err;
      start = last_addr + 32'd4;
      q.delete();
      foreach (pat[i]) begin
         dec_stall = pat[i];
         tick(1);
      end
      dec_stall = 1'b0;
      check(q.size() == pat.size() - stalls, {"R5 no bubble ", name}, q.size(), pat.size() - stalls);
      check_run(start, {"R5 no drop or repeat ", name});
      check(hold_err == h0, {"R4 held while stalled ", name}, hold_err, h0);
      check(ins_err == 0, {"R2 insn after stall ", name}, ins_err, 0);
   endtask

   task automatic t_redirect(input string name, input logic [31:0] tgt, input int pre_stall);
      logic [31:0] aligned;
      aligned = tgt & ~32'h3;
      dec_stall = (pre_stall > 0);
      if (pre_stall > 0) tick(pre_stall);
      redirect_valid = 1'b1;
      redirect_target = tgt;
      q.delete();
      @(negedge clk);
      check(out_valid == 1'b0, {"R7 invalid in redirect cycle ", name}, {31'b0, out_valid}, 0);
      @(posedge clk); #1;
      redirect_valid = 1'b0;
      dec_stall = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, {"R7 invalid after redirect ", name}, {31'b0, out_valid}, 0);
      tick(9);
      check(q.size() == 8, {"R7 refill count ", name}, q.size(), 8);
      check(q.size() > 0 && q[0] == aligned, {"R7 R8 first at target ", name},
            (q.size() > 0) ? q[0] : 32'hx, aligned);
      check_run(aligned, {"R7 run from target ", name});
   endtask

   task automatic t_debug();
      logic [31:0] l;
      dbg_stop = 1'b1;
      tick(4);
      l = last_addr;
      q.delete();
      tick(20);
      check(q.size() == 0 && out_valid == 1'b0, "R9 halted output quiet", q.size(), 0);
      dbg_step = 1'b1;
      tick(1);
      dbg_step = 1'b0;
      tick(6);
      check(q.size() == 1, "R10 exactly one stepped", q.size(), 1);
      check(q.size() > 0 && q[0] == l + 32'd4, "R10 step is next", (q.size() > 0) ? q[0] : 32'hx, l + 32'd4);
      dbg_stop = 1'b0;
      q.delete();
      tick(6);
      check(q.size() > 0 && q[0] == l + 32'd8, "R11 resume point", (q.size() > 0) ? q[0] : 32'hx, l + 32'd8);
      check_run(l + 32'd8, "R11 resume run");
   endtask

   initial begin
      #1;
      t_reset_stream();
      t_stall("single", '{1'b1, 1'b0, 1'b0, 1'b0}, 1);
      t_stall("four", '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 4);
      t_stall("alternate", '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, 5);
      t_redirect("plain", 32'h0000_2000, 0);
      t_redirect("misaligned", 32'h0000_3403, 0);
      t_redirect("during stall", 32'h0000_4800, 3);
      t_debug();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule